// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit repairs an accumulator byte after two packed-BCD bytes have been added with an ordinary binary adder. It takes the raw sum, the half-carry flag (carry out of bit 3 of that addition) and the carry flag (carry out of bit 7), and produces a byte in which each four-bit digit is again a decimal digit. It also produces an updated carry flag. The half-carry flag is an input only and is never written.

The unit is started by a one-cycle instruction strobe that comes with a 16-bit instruction word. It then steps through four named phases, one clock each, before it returns to idle. PH_DECODE compares the instruction word with the adjust opcode `16'h0007`. PH_FETCH samples the accumulator and both flags. PH_COMPUTE forms the corrected byte in a result register. PH_COMMIT copies that result to the outputs, but only if the opcode matched. The transitions are PH_IDLE→PH_DECODE (on an accepted strobe), PH_DECODE→PH_FETCH, PH_FETCH→PH_COMPUTE, PH_COMPUTE→PH_COMMIT and PH_COMMIT→PH_IDLE. Each of these happens unconditionally except the first. The digit count is a parameter. The lowest digit is forced by the half-carry flag and the top digit by the carry flag.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While reset is asserted and after it is released, `acc_out` is 0, `carry_out` is 0 and `busy` is 0.
- R2: If the low digit of the sampled accumulator is greater than 9, or the half-carry input was 1, the low digit gets 6 added to it. Otherwise it passes through unchanged.
- R3: The high digit first receives the carry out of the low-digit correction. If that sum is greater than 9, or the carry input was 1, 6 more is added. The result is the high digit of the output byte (A5h gives 05h, CEh gives 34h).
- R4: The carry output becomes 1 when the high-digit correction carries out of the top bit. It stays 1 if the carry input was 1. Otherwise it is 0.
- R5: Only the instruction word 16'h0007 updates the outputs. Any other word still runs the four phases, but `acc_out` and `carry_out` keep their values.
- R6: A strobe seen in PH_IDLE raises `busy` for exactly four cycles. New outputs are visible after the fourth rising edge that follows the accepting edge.
- R7: The accumulator and flag inputs are sampled at the second rising edge after the accepting edge. Changes to them after that edge do not affect the result.
- R8: A strobe that arrives while `busy` is 1 is ignored. No second instruction is started.
- R9: Between commits, `acc_out` and `carry_out` hold their values.
- R10: For any two valid packed-BCD bytes a and b, adjusting their binary sum (with the flags that addition produces) gives the BCD form of (a+b) mod 100, with `carry_out` equal to 1 exactly when a+b ≥ 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_strobe | input | 1 | Start request, sampled while idle |
| instr_word | input | OPW (16) | Instruction word presented with the strobe |
| acc_in | input | 4*DIGITS (8) | Accumulator value from the preceding addition |
| half_carry_in | input | 1 | Carry out of the low digit of that addition |
| carry_in | input | 1 | Carry out of the top digit of that addition |
| acc_out | output | 4*DIGITS (8) | Corrected accumulator |
| carry_out | output | 1 | Updated carry flag |
| busy | output | 1 | High during the four execution phases |

## Verification
Let k be the rising edge that accepts a strobe. `busy` rises after edge k and falls after edge k+4. The operands are taken at edge k+2, and `acc_out`/`carry_out` change at edge k+4. The bench runs a behavioural model that steps through the same edge count. It compares all three outputs at every falling edge, so a result that arrives one cycle early or late is caught. The directed and sweep checks sample at the falling edge after k+4. They change the operand inputs only after edge k+2 to show that the fetch instant is fixed.

// File: rtl/bcd_adjust_pkg.sv
package bcd_adjust_pkg;

    // Execution phases of one adjust instruction
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_DECODE  = 3'd1,
        PH_FETCH   = 3'd2,
        PH_COMPUTE = 3'd3,
        PH_COMMIT  = 3'd4
    } phase_t;

    // The single instruction word this unit executes
    localparam logic [15:0] ADJ_OPCODE = 16'h0007;

    // Largest value a decimal digit may hold
    localparam logic [4:0] DIGIT_MAX = 5'd9;

    // Correction added to a digit that overflowed its decimal range
    localparam logic [4:0] DIGIT_FIX = 5'd6;

endpackage

// File: rtl/bcd_adjust_seq.sv
module bcd_adjust_seq
    import bcd_adjust_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase,
    output logic   busy,
    output logic   en_decode,
    output logic   en_fetch,
    output logic   en_compute,
    output logic   en_commit
);

    phase_t phase_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end

    // Transitions
    always_comb begin
        phase_nxt = PH_IDLE;
        unique case (phase)
            PH_IDLE:    phase_nxt = start ? PH_DECODE : PH_IDLE;
            PH_DECODE:  phase_nxt = PH_FETCH;
            PH_FETCH:   phase_nxt = PH_COMPUTE;
            PH_COMPUTE: phase_nxt = PH_COMMIT;
            PH_COMMIT:  phase_nxt = PH_IDLE;
            default:    phase_nxt = PH_IDLE;
        endcase
    end

    // Phase-decoded enables
    always_comb begin
        busy       = 1'b1;
        en_decode  = 1'b0;
        en_fetch   = 1'b0;
        en_compute = 1'b0;
        en_commit  = 1'b0;
        unique case (phase)
            PH_IDLE:    busy       = 1'b0;
            PH_DECODE:  en_decode  = 1'b1;
            PH_FETCH:   en_fetch   = 1'b1;
            PH_COMPUTE: en_compute = 1'b1;
            PH_COMMIT:  en_commit  = 1'b1;
            default:    busy       = 1'b0;
        endcase
    end

    // R6: every commit phase is followed by idle
    a_r6_commit_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COMMIT) |=> (phase == PH_IDLE));

    // R8: a running instruction never restarts decode
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> (phase != PH_DECODE));

    // R6: decode always leads to fetch
    a_r6_decode_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE) |=> (phase == PH_FETCH));

endmodule

// File: rtl/bcd_adjust_decode.sv
module bcd_adjust_decode
    import bcd_adjust_pkg::*;
#(
    parameter int OPW = 16
) (
    input  logic [OPW-1:0] word,
    output logic           hit
);

    localparam logic [OPW-1:0] MATCH_WORD = OPW'(ADJ_OPCODE);

    // R5: only the exact adjust word is a match
    always_comb begin
        hit = (word == MATCH_WORD);
    end

endmodule

// File: rtl/bcd_adjust_chain.sv
module bcd_adjust_chain
    import bcd_adjust_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] value,
    input  logic         low_force,
    input  logic         high_force,
    output logic [W-1:0] adjusted,
    output logic         carry_out
);

    logic [DIGITS:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [4:0] sum;
        logic [4:0] fixed;
        logic       force_fix;

        if (i == 0) begin : g_low
            // R2: lowest digit is forced by the half-carry flag
            if (DIGITS == 1) begin : g_single
                assign force_fix = low_force | high_force;
            end else begin : g_multi
                assign force_fix = low_force;
            end
        end else if (i == DIGITS - 1) begin : g_high
            // R3: top digit is forced by the carry flag
            assign force_fix = high_force;
        end else begin : g_mid
            assign force_fix = 1'b0;
        end

        always_comb begin
            sum   = {1'b0, value[4*i +: 4]} + {4'b0000, cy[i]};
            fixed = ((sum > DIGIT_MAX) || force_fix) ? (sum + DIGIT_FIX) : sum;
        end

        assign adjusted[4*i +: 4] = fixed[3:0];
        assign cy[i+1]            = fixed[4];
    end

    assign carry_out = cy[DIGITS];

endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
    import bcd_adjust_pkg::*;
#(
    parameter int DIGITS = 2,
    parameter int OPW    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_strobe,
    input  logic [OPW-1:0]        instr_word,
    input  logic [4*DIGITS-1:0]   acc_in,
    input  logic                  half_carry_in,
    input  logic                  carry_in,
    output logic [4*DIGITS-1:0]   acc_out,
    output logic                  carry_out
    ,
    output logic                  busy
);

    localparam int W = 4 * DIGITS;

    phase_t         phase;
    logic           en_decode;
    logic           en_fetch;
    logic           en_compute;
    logic           en_commit;
    logic           accept;

    logic [OPW-1:0] op_q;
    logic           hit_now;
    logic           hit_q;
    logic [W-1:0]   w_q;
    logic           dc_q;
    logic           c_q;
    logic [W-1:0]   adj_w;
    logic           adj_cy;
    logic [W-1:0]   res_q;
    logic           res_c_q;

    assign accept = instr_strobe & ~busy;

    bcd_adjust_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (instr_strobe),
        .phase      (phase),
        .busy       (busy),
        .en_decode  (en_decode),
        .en_fetch   (en_fetch),
        .en_compute (en_compute),
        .en_commit  (en_commit)
    );

    bcd_adjust_decode #(.OPW(OPW)) u_dec (
        .word (op_q),
        .hit  (hit_now)
    );

    bcd_adjust_chain #(.DIGITS(DIGITS)) u_chain (
        .value      (w_q),
        .low_force  (dc_q),
        .high_force (c_q),
        .adjusted   (adj_w),
        .carry_out  (adj_cy)
    );

    // Instruction capture and decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            hit_q <= 1'b0;
        end else begin
            if (accept) begin
                op_q <= instr_word;
            end
            if (en_decode) begin
                hit_q <= hit_now;
            end
        end
    end

    // R7: operand fetch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q  <= '0;
            dc_q <= 1'b0;
            c_q  <= 1'b0;
        end else if (en_fetch) begin
            w_q  <= acc_in;
            dc_q <= half_carry_in;
            c_q  <= carry_in;
        end
    end

    // Compute phase result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            res_c_q <= 1'b0;
        end else if (en_compute) begin
            res_q   <= adj_w;
            res_c_q <= adj_cy | c_q;   // R4: carry is sticky
        end
    end

    // Commit to outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_out   <= '0;
            carry_out <= 1'b0;
        end else if (en_commit && hit_q) begin
            acc_out   <= res_q;
            carry_out <= res_c_q;
        end
    end

    // R9: outputs move only in a commit phase
    a_r9_hold_outside_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !en_commit |=> ($stable(acc_out) && $stable(carry_out)));

    // R5: a non-matching word leaves the outputs alone
    a_r5_nomatch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_commit && !hit_q) |=> ($stable(acc_out) && $stable(carry_out)));

    // R4: an incoming carry survives to the output
    a_r4_carry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (en_commit && hit_q && c_q) |=> carry_out);

    // R7: operands are frozen outside the fetch phase
    a_r7_operand_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_fetch |=> ($stable(w_q) && $stable(dc_q) && $stable(c_q)));

endmodule

// File: tb/bcd_adjust_unit_test.sv
module bcd_adjust_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_strobe = 1'b0;
    logic [15:0] instr_word = '0;
    logic [7:0]  acc_in = '0;
    logic        half_carry_in = 1'b0;
    logic        carry_in = 1'b0;
    logic [7:0]  acc_out;
    logic        carry_out;
    logic        busy;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bcd_adjust_unit uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_strobe  (instr_strobe),
        .instr_word    (instr_word),
        .acc_in        (acc_in),
        .half_carry_in (half_carry_in),
        .carry_in      (carry_in),
        .acc_out       (acc_out),
        .carry_out     (carry_out),
        .busy          (busy)
    );

    // Reference model stepped per edge
    int       m_cnt = 0;
    bit       m_hit = 0;
    int       m_w = 0;
    bit       m_c = 0;
    int       m_pw = 0;
    bit       m_pc = 0;

    function automatic void ref_adjust(input int w, input bit dc, input bit c,
                                       output int ow, output bit oc);
        int lo;
        int hi;
        lo = w % 16;
        hi = w / 16;
        if (lo > 9 || dc) lo = lo + 6;
        hi = hi + lo / 16;
        lo = lo % 16;
        if (hi > 9 || c) hi = hi + 6;
        oc = c || (hi >= 16);
        ow = (hi % 16) * 16 + lo;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_w = 0; m_c = 0;
        end else if (m_cnt == 0) begin
            if (instr_strobe) begin
                m_cnt = 4;
                m_hit = (instr_word == 16'h0007);
            end
        end else begin
            if (m_cnt == 3) ref_adjust(int'(acc_in), half_carry_in, carry_in, m_pw, m_pc);
            if (m_cnt == 1 && m_hit) begin
                m_w = m_pw; m_c = m_pc;
            end
            m_cnt = m_cnt - 1;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(acc_out) != m_w || carry_out != m_c) begin
                errors++;
                $display("FAIL R9 per-cycle: acc=%02h c=%0d expected acc=%02h c=%0d",
                         acc_out, carry_out, m_w[7:0], m_c);
            end
            checks++;
            if (busy != (m_cnt != 0)) begin
                errors++;
                $display("FAIL R6 per-cycle busy: actual=%0d expected=%0d", busy, (m_cnt != 0));
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one instruction; returns at the falling edge after edge k+4
    task automatic run_op(input logic [15:0] word, input logic [7:0] w, input bit dc,
                          input bit c, input bit scramble, input bit hold_strobe);
        instr_strobe  = 1'b1;
        instr_word    = word;
        acc_in        = w;
        half_carry_in = dc;
        carry_in      = c;
        @(posedge clk);                         // edge k
        @(negedge clk);
        if (!hold_strobe) instr_strobe = 1'b0;
        else instr_word = 16'h0007;
        @(posedge clk);                         // k+1
        @(posedge clk);                         // k+2 fetch
        @(negedge clk);
        if (scramble) begin
            acc_in = ~w; half_carry_in = ~dc; carry_in = ~c;
        end
        @(posedge clk);                         // k+3
        @(posedge clk);                         // k+4 commit
        @(negedge clk);
        instr_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 acc during reset", acc_out, 0);
        check("R1 carry during reset", carry_out, 0);
        check("R1 busy during reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 acc after reset", acc_out, 0);
        check("R1 busy after reset", busy, 0);

        // R3 R4: A5h -> 05h, carry 1
        run_op(16'h0007, 8'hA5, 0, 0, 0, 0);
        check("R3 A5 acc", acc_out, 8'h05);
        check("R4 A5 carry", carry_out, 1);
        check("R6 idle after A5", busy, 0);

        // R2 R3: CEh -> 34h, low carry ripples upward
        run_op(16'h0007, 8'hCE, 0, 0, 0, 0);
        check("R3 CE acc", acc_out, 8'h34);
        check("R4 CE carry", carry_out, 1);

        // R2: half-carry forces low digit
        run_op(16'h0007, 8'h03, 1, 0, 0, 0);
        check("R2 dc force acc", acc_out, 8'h09);
        check("R4 no carry", carry_out, 0);

        // R2: no correction needed
        run_op(16'h0007, 8'h47, 0, 0, 0, 0);
        check("R2 pass-through acc", acc_out, 8'h47);

        // R4: incoming carry forces high digit and stays set
        run_op(16'h0007, 8'h12, 0, 1, 0, 0);
        check("R4 c force acc", acc_out, 8'h72);
        check("R4 c sticky", carry_out, 1);

        // R3: FFh ripples through both digits
        run_op(16'h0007, 8'hFF, 0, 0, 0, 0);
        check("R3 FF acc", acc_out, 8'h65);
        check("R4 FF carry", carry_out, 1);

        // R5: other words leave outputs as they were
        run_op(16'h0008, 8'h11, 0, 0, 0, 0);
        check("R5 nomatch acc", acc_out, 8'h65);
        check("R5 nomatch carry", carry_out, 1);
        run_op(16'h8007, 8'h22, 1, 0, 0, 0);
        check("R5 high-bit word acc", acc_out, 8'h65);

        // R7: operands changed after fetch have no effect
        run_op(16'h0007, 8'h38, 1, 0, 1, 0);
        check("R7 scramble acc", acc_out, 8'h3E);
        check("R7 scramble carry", carry_out, 0);

        // R8: strobe held through the run does not restart
        run_op(16'h0007, 8'h0B, 0, 0, 0, 1);
        check("R8 acc", acc_out, 8'h11);
        check("R8 busy low after run", busy, 0);

        // R9: outputs hold while idle
        repeat (5) @(negedge clk);
        check("R9 idle hold", acc_out, 8'h11);

        // R10: sweep all valid BCD pairs
        for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
                int ab;
                int bb;
                int raw;
                int want;
                ab   = (a / 10) * 16 + (a % 10);
                bb   = (b / 10) * 16 + (b % 10);
                raw  = ab + bb;
                want = (((a + b) % 100) / 10) * 16 + ((a + b) % 10);
                run_op(16'h0007, raw[7:0], ((ab % 16) + (bb % 16)) > 15, raw > 255, 0, 0);
                check("R10 sweep acc", acc_out, want);
                check("R10 sweep carry", carry_out, (a + b) >= 100);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule